// File: doc/BRIEF.md
# Bridge PWM Output Controller

This block generates one pulse-width modulated waveform and drives it onto four output pins, A to D. A 10-bit count sets the waveform. Its upper eight bits come from a period timer and its lower two bits from a fine counter, and it advances once for every clock on which the tick enable is high. The waveform is active while that count is below a 10-bit duty value. A new period begins when the timer has reached the period value and the fine counter has reached its last step. At that boundary the period and duty inputs are captured, so a change to either input never alters a period that is already running.

A 2-bit output-mode input decides how the waveform reaches the pins. In single mode only pin A carries the waveform. In half-bridge mode A carries the waveform and B carries its complement, with a programmable dead time added on every turn-on. The two full-bridge modes hold one pin of the bridge on and modulate the diagonal pin, one mode for each direction. A request to reverse the bridge is handled near the end of the current period: the modulated pin is blanked and the steady pins swap, and modulation starts again in the next period. Two polarity bits make each pin pair active-high or active-low. A period-start strobe marks each boundary. A valid flag tells the system when a full period has passed since reset, which is the point at which the pin drivers may be switched on.

Top module: `hbridge_pwm_ctrl`

## Requirements
- R1: While reset is low, all pin levels are 0, `pin_drv_o` is 0001, and `prd_start_o` and `out_valid_o` are 0. Reset clears both buffered values (period and duty) to 0, so the first period after reset lasts 4 enabled cycles and stays inactive throughout.
- R2: `prd_start_o` is high for exactly one clock at the first cycle of each period. A period lasts 4*(P+1) enabled cycles, where P is the period value captured at the previous boundary. Clocks with `tick_en` low are not counted.
- R3: Within a period, the waveform is active for the first D enabled counts, where D is the duty value captured at the period start. A duty of 0 gives no active cycle. A duty of at least 4*(P+1) keeps the waveform active for the whole period.
- R4: With mode 00, pin A carries the waveform without dead time, `pin_drv_o` is 0001, and pins B, C and D are released and read as level 0.
- R5: With mode 10, pin A carries the waveform, pin B carries its complement, `pin_drv_o` is 0011, and pins C and D are released and read as level 0.
- R6: In mode 10, when a pin turns from inactive to active with a dead-time value N greater than 0, the pin stays inactive for the cycle in which the waveform changes. It then stays inactive for N-1 further enabled cycles. An active-to-inactive change takes effect at once. N = 0 adds no delay, and A and B are never active together.
- R7: With mode 01, A is held active, B and C are held inactive, D carries the waveform without dead time, and `pin_drv_o` is 1111.
- R8: With mode 11, C is held active, A and D are held inactive, B carries the waveform without dead time, and `pin_drv_o` is 1111.
- R9: The polarity input uses bit 1 for the A/C pair and bit 0 for the B/D pair. A 1 makes that pair active-low, so a driven pin's level is its active state XOR the pair's bit. The supported codes are 1100, 1101, 1110 and 1111.
- R10: A change between modes 01 and 11 waits until the timer enters the last four timer values of the period, that is, timer + 4 > P. On the first clock inside that window, the fixed pins switch to the new direction and the modulated pin is forced inactive until the period ends. Modulation resumes when the next period starts. Any other mode change takes effect on the next clock.
- R11: `out_valid_o` rises together with the first `prd_start_o` after reset, which is the start of the second period. It then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Instruction-cycle enable; the count and the dead time advance only when it is high |
| period_in | input | 8 | Period value P, captured at each period start |
| duty_in | input | 10 | Duty value D, captured at each period start |
| mode_in | input | 2 | Output mode: 00 single, 01 full-bridge forward, 10 half-bridge, 11 full-bridge reverse |
| pol_in | input | 4 | Polarity code 11xx; bit 1 inverts A/C, bit 0 inverts B/D |
| dband_in | input | 7 | Dead-time length N in enabled cycles |
| pin_o | output | 4 | Pin levels, bit 0 = A to bit 3 = D |
| pin_drv_o | output | 4 | High for each pin the block drives in the current mode |
| prd_start_o | output | 1 | One-clock strobe at each period start |
| out_valid_o | output | 1 | High once a complete period has passed since reset |

## Verification
A behavioural model compares every output on every clock while the bench steps through a series of input patterns. Three duty values are used: a mid-range value, zero and full scale. Together they separate the comparison edge from the two saturated cases. Half-bridge runs with dead times of 5 and 0 show whether the delay applies to turn-on only, and inverted polarity with an asymmetric duty shows which pair each polarity bit controls. Holding the duty at full scale makes the direction reversal visible. The pin high counts must then be exactly 25 and 15, which pins down the cycle on which the window opens, and a run with `tick_en` toggling shows that the count and the dead time pause on disabled cycles.

// File: rtl/hbpwm_pkg.sv
// Package: shared types and helpers of the bridge PWM controller.
// Assumes pin index 0..3 maps to pins A..D.
package hbpwm_pkg;

    typedef enum logic [1:0] {
        OM_SINGLE = 2'b00,
        OM_FWD    = 2'b01,
        OM_HALF   = 2'b10,
        OM_REV    = 2'b11
    } out_mode_e;

    localparam int PIN_N = 4;

    // True for both full-bridge directions (low mode bit set).
    function automatic logic is_bridge(input logic [1:0] m);
        return m[0];
    endfunction

endpackage

// File: rtl/hbp_timebase.sv
// Period timebase: a timer with a fine sub-count, buffered period and duty
// values, the raw PWM compare, the period-start strobe and the valid flag.
// Assumes: duty width equals timer width plus fine width; the count only
// advances on cycles with tick_en high.
module hbp_timebase #(
    parameter int TMR_W  = 8,
    parameter int FINE_W = 2,
    localparam int DUTY_W = TMR_W + FINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [TMR_W-1:0]  period_in,
    input  logic [DUTY_W-1:0] duty_in,
    output logic [TMR_W-1:0]  tmr_o,
    output logic [TMR_W-1:0]  prd_o,
    output logic              raw_o,
    output logic              wrap_o,
    output logic              start_o,
    output logic              valid_o
);

    localparam logic [FINE_W-1:0] FINE_LAST = {FINE_W{1'b1}};

    logic [TMR_W-1:0]  tmr_q, prd_q;
    logic [FINE_W-1:0] fine_q;
    logic [DUTY_W-1:0] duty_q;
    logic              start_q, valid_q, wrap;

    // Period ends on the enabled cycle that sits at the last fine step of the last timer value.
    assign wrap = tick_en && (tmr_q == prd_q) && (fine_q == FINE_LAST);

    // Advance the count, reload buffers at the boundary, flag the new period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q   <= '0;
            fine_q  <= '0;
            prd_q   <= '0;
            duty_q  <= '0;
            start_q <= 1'b0;
            valid_q <= 1'b0;
        end else if (wrap) begin
            tmr_q   <= '0;
            fine_q  <= '0;
            prd_q   <= period_in;
            duty_q  <= duty_in;
            start_q <= 1'b1;
            valid_q <= 1'b1;
        end else begin
            start_q <= 1'b0;
            if (tick_en) begin
                fine_q <= fine_q + FINE_W'(1);
                if (fine_q == FINE_LAST) tmr_q <= tmr_q + TMR_W'(1);
            end
        end
    end

    // Raw waveform: active while the extended count is below the duty value.
    always_comb raw_o = {tmr_q, fine_q} < duty_q;

    assign tmr_o   = tmr_q;
    assign prd_o   = prd_q;
    assign wrap_o  = wrap;
    assign start_o = start_q;
    assign valid_o = valid_q;

    // R2: the timer never runs past the buffered period.
    a_r2_tmr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q <= prd_q);
    // R2: buffered period and duty only change at a boundary.
    a_r2_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> ($stable(prd_q) && $stable(duty_q)));
    // R2: the strobe lasts a single clock (a period is at least four cycles).
    a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q);
    // R11: once valid, it stays valid until reset.
    a_r11_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> valid_q);

endmodule

// File: rtl/hbp_deadband.sv
// Dead-time generator: on every change of the raw waveform it reports a
// hold that keeps the turning-on pin inactive for the programmed number of
// enabled cycles. Assumes the raw waveform is a registered-state function.
module hbp_deadband #(
    parameter int DB_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    input  logic            raw_i,
    input  logic [DB_W-1:0] dband_i,
    output logic            hold_o
);

    logic            raw_q;
    logic [DB_W-1:0] cnt_q;
    logic            chg;

    assign chg = (raw_i != raw_q);

    // Hold during the change cycle itself and while the remaining count is nonzero.
    always_comb hold_o = chg ? (dband_i != '0) : (cnt_q != '0);

    // Track the waveform and count the remaining dead time in enabled cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            raw_q <= raw_i;
            if (chg)
                cnt_q <= (dband_i == '0) ? '0 : dband_i - DB_W'(1);
            else if (tick_en && cnt_q != '0)
                cnt_q <= cnt_q - DB_W'(1);
        end
    end

    // R6: the remaining count only moves on enabled cycles or a new change.
    a_r6_count_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !chg) |=> $stable(cnt_q));

endmodule

// File: rtl/hbp_pinmap.sv
// Pin mapper and direction sequencer: holds the applied output mode, defers
// full-bridge reversals to the end-of-period window with blanking, and
// applies per-pair polarity. Assumes pins 0..3 are A..D.
module hbp_pinmap
    import hbpwm_pkg::*;
#(
    parameter int TMR_W = 8,
    parameter int LEAD  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_in,
    input  logic [3:0]       pol_in,
    input  logic             raw_i,
    input  logic             hold_i,
    input  logic [TMR_W-1:0] tmr_i,
    input  logic [TMR_W-1:0] prd_i,
    input  logic             wrap_i,
    output logic [PIN_N-1:0] pin_o,
    output logic [PIN_N-1:0] drv_o
);

    localparam logic [TMR_W:0] LEAD_V = (TMR_W+1)'(LEAD);

    out_mode_e        mode_q;
    logic             blank_q;
    logic             in_win, need_seq, swap;
    logic [PIN_N-1:0] act;

    // Window of the last LEAD timer values of the period.
    assign in_win   = ({1'b0, tmr_i} + LEAD_V) > {1'b0, prd_i};
    assign need_seq = is_bridge(mode_q) && is_bridge(mode_in) && (mode_in != mode_q);
    assign swap     = need_seq && in_win;

    // Apply mode changes; bridge reversals wait for the window and blank the modulated pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= OM_SINGLE;
            blank_q <= 1'b0;
        end else begin
            if (!need_seq || in_win) mode_q <= out_mode_e'(mode_in);
            if (wrap_i)    blank_q <= 1'b0;
            else if (swap) blank_q <= 1'b1;
        end
    end

    // Active states of the four pins for the applied mode.
    always_comb begin
        act   = '0;
        drv_o = '0;
        unique case (mode_q)
            OM_SINGLE: begin
                act[0] = raw_i;
                drv_o  = 4'b0001;
            end
            OM_HALF: begin
                act[0] = raw_i && !hold_i;
                act[1] = !raw_i && !hold_i;
                drv_o  = 4'b0011;
            end
            OM_FWD: begin
                act[0] = 1'b1;
                act[3] = raw_i && !blank_q;
                drv_o  = 4'b1111;
            end
            OM_REV: begin
                act[2] = 1'b1;
                act[1] = raw_i && !blank_q;
                drv_o  = 4'b1111;
            end
            default: ;
        endcase
    end

    // Per-pin polarity: even pins follow the A/C bit, odd pins the B/D bit.
    for (genvar gi = 0; gi < PIN_N; gi++) begin : g_pin
        localparam int POL_BIT = (gi % 2 == 0) ? 1 : 0;
        assign pin_o[gi] = drv_o[gi] & (act[gi] ^ pol_in[POL_BIT]);
    end

    // R10: a reversal between bridge directions is only applied inside the window.
    a_r10_swap_window: assert property (@(posedge clk) disable iff (!rst_n)
        (is_bridge($past(mode_q)) && is_bridge(mode_q) && mode_q != $past(mode_q))
        |-> $past(in_win));
    // R10: while blanked, the modulated pin of a bridge direction stays inactive.
    a_r10_blank_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_q && mode_q == OM_FWD) |-> !act[3]);
    a_r10_blank_rev: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_q && mode_q == OM_REV) |-> !act[1]);
    // R6: the complementary half-bridge pins are never active together.
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == OM_HALF) |-> !(act[0] && act[1]));
    // R6: with dead time, pin A turns on only after the waveform was already high.
    a_r6_late_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(act[0]) && mode_q == OM_HALF && $past(mode_q) == OM_HALF
         && $past(dband_nz_q)) |-> $past(raw_i));

    logic dband_nz_q;
    // Record whether the previous cycle had a dead time in force (for the check above).
    always_ff @(posedge clk) begin
        if (!rst_n) dband_nz_q <= 1'b0;
        else        dband_nz_q <= hold_i || (raw_i && !act[0] && mode_q == OM_HALF);
    end

endmodule

// File: rtl/hbridge_pwm_ctrl.sv
// Top of the bridge PWM controller: timebase, dead-time generator and pin
// mapper. Assumes a 10-bit duty built from the 8-bit timer and a 2-bit fine count.
module hbridge_pwm_ctrl
    import hbpwm_pkg::*;
#(
    parameter int TMR_W  = 8,
    parameter int FINE_W = 2,
    parameter int DB_W   = 7,
    parameter int LEAD   = 4,
    localparam int DUTY_W = TMR_W + FINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [TMR_W-1:0]  period_in,
    input  logic [DUTY_W-1:0] duty_in,
    input  logic [1:0]        mode_in,
    input  logic [3:0]        pol_in,
    input  logic [DB_W-1:0]   dband_in,
    output logic [3:0]        pin_o,
    output logic [3:0]        pin_drv_o,
    output logic              prd_start_o,
    output logic              out_valid_o
);

    logic [TMR_W-1:0] tmr, prd;
    logic             raw, wrap, hold;

    hbp_timebase #(.TMR_W(TMR_W), .FINE_W(FINE_W)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .period_in (period_in),
        .duty_in   (duty_in),
        .tmr_o     (tmr),
        .prd_o     (prd),
        .raw_o     (raw),
        .wrap_o    (wrap),
        .start_o   (prd_start_o),
        .valid_o   (out_valid_o)
    );

    hbp_deadband #(.DB_W(DB_W)) u_db (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .raw_i   (raw),
        .dband_i (dband_in),
        .hold_o  (hold)
    );

    hbp_pinmap #(.TMR_W(TMR_W), .LEAD(LEAD)) u_pm (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_in (mode_in),
        .pol_in  (pol_in),
        .raw_i   (raw),
        .hold_i  (hold),
        .tmr_i   (tmr),
        .prd_i   (prd),
        .wrap_i  (wrap),
        .pin_o   (pin_o),
        .drv_o   (pin_drv_o)
    );

    // R11: the valid flag appears together with a period-start strobe.
    a_r11_valid_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid_o) |-> prd_start_o);

endmodule

// File: tb/hbridge_pwm_ctrl_tb_top.sv
// Bench: behavioural reference model compared on every clock, plus directed
// per-period measurements of pin activity.
module hbridge_pwm_ctrl_tb_top;

    localparam int CLK_NS  = 10;
    localparam int WD_CYC  = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic [7:0] period_in = 8'd9;
    logic [9:0] duty_in = 10'd20;
    logic [1:0] mode_in = 2'b00;
    logic [3:0] pol_in = 4'b1100;
    logic [6:0] dband_in = 7'd3;
    logic [3:0] pin_o, pin_drv_o;
    logic       prd_start_o, out_valid_o;

    int    n_chk = 0;
    int    n_bad = 0;
    string tag = "R1";
    bit    toggle_tick = 1'b0;
    bit    started = 1'b0;

    hbridge_pwm_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .period_in(period_in),
        .duty_in(duty_in), .mode_in(mode_in), .pol_in(pol_in), .dband_in(dband_in),
        .pin_o(pin_o), .pin_drv_o(pin_drv_o), .prd_start_o(prd_start_o),
        .out_valid_o(out_valid_o)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // ---------------- reference model ----------------
    int m_cnt, m_prd, m_duty, m_mode, m_dbc;
    bit m_start, m_valid, m_blank, m_rawq;

    function automatic bit m_raw();
        return m_cnt < m_duty;
    endfunction

    always @(posedge clk) begin
        bit r, wr, win, need;
        started = 1'b1;
        if (!rst_n) begin
            m_cnt = 0; m_prd = 0; m_duty = 0; m_mode = 0; m_dbc = 0;
            m_start = 0; m_valid = 0; m_blank = 0; m_rawq = 0;
        end else begin
            r    = m_raw();
            wr   = tick_en && (m_cnt == 4 * m_prd + 3);
            win  = (m_cnt / 4 + 4) > m_prd;
            need = (m_mode % 2 == 1) && (mode_in[0] == 1'b1) && (m_mode != int'(mode_in));
            if (r != m_rawq) m_dbc = (dband_in == 0) ? 0 : int'(dband_in) - 1;
            else if (tick_en && m_dbc > 0) m_dbc--;
            m_rawq = r;
            if (wr) m_blank = 0;
            else if (need && win) m_blank = 1;
            if (!need || win) m_mode = int'(mode_in);
            if (wr) begin
                m_cnt = 0; m_prd = int'(period_in); m_duty = int'(duty_in);
                m_start = 1; m_valid = 1;
            end else begin
                m_start = 0;
                if (tick_en) m_cnt++;
            end
        end
    end

    // Compare every output at the falling edge.
    always @(negedge clk) begin
        bit r, h;
        bit [3:0] a, d, p;
        if (started) begin
            r = m_raw();
            h = (r != m_rawq) ? (dband_in != 0) : (m_dbc != 0);
            a = 4'b0000;
            case (m_mode)
                0: begin a[0] = r; d = 4'b0001; end
                2: begin a[0] = r && !h; a[1] = !r && !h; d = 4'b0011; end
                1: begin a[0] = 1; a[3] = r && !m_blank; d = 4'b1111; end
                default: begin a[2] = 1; a[1] = r && !m_blank; d = 4'b1111; end
            endcase
            for (int i = 0; i < 4; i++)
                p[i] = d[i] & (a[i] ^ ((i % 2 == 0) ? pol_in[1] : pol_in[0]));
            check({tag, " pins"}, int'(pin_o), int'(p));
            check({tag, " drv"}, int'(pin_drv_o), int'(d));
            check("R2 start strobe", int'(prd_start_o), int'(m_start));
            check("R11 valid", int'(out_valid_o), int'(m_valid));
        end
    end

    // Optional tick gating: alternate the enable every clock.
    always @(negedge clk) if (toggle_tick) #1 tick_en = ~tick_en;

    // ---------------- directed measurement ----------------
    int c_len;
    int c_pin[4];

    task automatic wait_start();
        do @(negedge clk); while (!prd_start_o);
    endtask

    // Counts from the current strobe cycle up to the next strobe.
    task automatic measure();
        c_len = 0;
        for (int i = 0; i < 4; i++) c_pin[i] = 0;
        do begin
            c_len++;
            for (int i = 0; i < 4; i++) c_pin[i] += int'(pin_o[i]);
            @(negedge clk);
        end while (!prd_start_o);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 pins", int'(pin_o), 0);
        check("R1 drv", int'(pin_drv_o), 1);
        check("R1 start", int'(prd_start_o), 0);
        check("R11 valid low before first period ends", int'(out_valid_o), 0);
        #1 rst_n = 1'b1;

        // R4 single mode, R2 period length, R11 valid
        tag = "R4";
        wait_start();
        check("R11 valid at first strobe", int'(out_valid_o), 1);
        measure();
        check("R2 period length", c_len, 40);
        check("R4 pin A active count", c_pin[0], 20);
        check("R4 pin B released", c_pin[1], 0);

        // R3 duty zero and full
        tag = "R3";
        duty_in = 10'd0;
        measure(); measure();
        check("R3 zero duty A count", c_pin[0], 0);
        duty_in = 10'd1023;
        measure(); measure();
        check("R3 full duty A count", c_pin[0], 40);

        // R5 and R6 half-bridge with dead time
        tag = "R5 R6";
        mode_in = 2'b10; duty_in = 10'd20; dband_in = 7'd5;
        measure(); measure(); measure();
        check("R6 A count with dead time 5", c_pin[0], 15);
        check("R6 B count with dead time 5", c_pin[1], 15);
        check("R5 C released", c_pin[2], 0);
        dband_in = 7'd0;
        measure(); measure();
        check("R6 A count no dead time", c_pin[0], 20);
        check("R5 B complement count", c_pin[1], 20);

        // R9 polarity inversion on both pairs
        tag = "R9";
        pol_in = 4'b1111; duty_in = 10'd12;
        measure(); measure();
        check("R9 inverted A high count", c_pin[0], 28);
        check("R9 inverted B high count", c_pin[1], 12);

        // R7 forward bridge, R10 reversal, R8 reverse bridge
        tag = "R7";
        pol_in = 4'b1100; mode_in = 2'b01; duty_in = 10'd1023;
        measure(); measure();
        check("R7 A held active", c_pin[0], 40);
        check("R7 B inactive", c_pin[1], 0);
        check("R7 C inactive", c_pin[2], 0);
        check("R7 D modulated full", c_pin[3], 40);
        tag = "R10";
        mode_in = 2'b11;
        measure();
        check("R10 A until window", c_pin[0], 25);
        check("R10 D until window", c_pin[3], 25);
        check("R10 C after window", c_pin[2], 15);
        check("R10 B blanked", c_pin[1], 0);
        tag = "R8";
        measure();
        check("R8 A inactive", c_pin[0], 0);
        check("R8 B modulated full", c_pin[1], 40);
        check("R8 C held active", c_pin[2], 40);
        check("R8 D inactive", c_pin[3], 0);

        // R2 and R6 with a gated enable
        tag = "R2 R6 gated";
        mode_in = 2'b10; duty_in = 10'd20; dband_in = 7'd3;
        toggle_tick = 1'b1;
        measure(); measure(); measure();
        check("R2 gated period length", c_len, 80);
        toggle_tick = 1'b0;
        repeat (4) @(negedge clk);
        summary();
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

endmodule